// File: doc/BRIEF.md
# Receive Flow-Control Credit Advertiser

This block sits on the receive side of a PCIe-style endpoint. It tracks the header and data credits that the endpoint grants its link partner for posted and non-posted traffic, and it decides when an UpdateFC packet has to go out and what it carries. The packet itself, including its CRC, is built elsewhere. Completion credits are always advertised as infinite, so completions are accepted at once.

Each finite type has a fixed pool of credits. Posted headers have 2, posted data has 16 (256 bytes), non-posted headers have 2 and non-posted data has 2. A consume strobe marks a buffer as taken. A return strobe marks it as freed. A freed buffer raises the type's cumulative credits-allocated count by one, and an update request for that type follows at once. Each type also has its own refresh timer, driven by a microsecond tick. The timer re-advertises the type while the link is active. Any update sent for a type restarts that type's timer.

The update port holds one request, made of the type and the cumulative count. The request stays on the port until a one-cycle acknowledge takes it. When several types are waiting, a fixed priority picks the next one.

Top module: `rx_fc_credit_adv`

## Requirements
- R1: After reset the advertised limits are 2 (posted header), 16 (posted data), 2 (non-posted header) and 2 (non-posted data). Every free count equals its pool size, and `upd_valid` is 0.
- R2: Both completion limit outputs always read 0, which is the code for infinite.
- R3: A consume strobe lowers that type's free count by one and leaves its limit unchanged. A consume strobe while the free count is 0 has no effect.
- R4: A return strobe while the free count is below the pool size raises the free count and the limit by one. It also puts an update for that type on the port at the same clock edge. A return strobe while the free count is already full is ignored and raises no update.
- R5: Type codes are 0 posted header, 1 posted data, 2 non-posted header and 3 non-posted data. When several types are waiting, the lowest code is served first.
- R6: While `upd_valid` is 1 and `upd_ack` is 0, `upd_valid` and `upd_type` hold their values. An acknowledge removes the presented request at that edge.
- R7: `upd_count` is the cumulative limit of the presented type. Header counts wrap modulo 256 and are zero-extended to 12 bits. Data counts wrap modulo 4096.
- R8: While `link_state` is 1 or 2 (active), a type whose last update is 30 ticks old gets a refresh update on the edge that takes its 30th tick. It never gets one earlier.
- R9: With `ext_sync` at 1 the refresh interval becomes 120 ticks.
- R10: For any other `link_state` code, the refresh timers are held at zero and no refresh is raised. On re-entry to an active state, counting starts again from zero.
- R11: Sending an update for a type restarts that type's refresh timer, whether the update came from a freed credit or from a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_state | input | 3 | Link-state code: 1 and 2 are active, all others inactive |
| ext_sync | input | 1 | Selects the long refresh interval |
| us_tick | input | 1 | One-cycle microsecond pulse |
| credit_take | input | 4 | Consume strobe for each type, bit = type code |
| credit_return | input | 4 | Buffer-freed strobe for each type, bit = type code |
| upd_ack | input | 1 | One-cycle acknowledge of the presented update |
| upd_valid | output | 1 | An update request is presented |
| upd_type | output | 2 | Type code of the presented update |
| upd_count | output | 12 | Cumulative limit for the presented type |
| lim_ph | output | 8 | Posted-header limit snapshot |
| lim_pd | output | 12 | Posted-data limit snapshot |
| lim_nph | output | 8 | Non-posted-header limit snapshot |
| lim_npd | output | 12 | Non-posted-data limit snapshot |
| lim_cplh | output | 8 | Completion-header limit (0 means infinite) |
| lim_cpld | output | 12 | Completion-data limit (0 means infinite) |
| avail | output | 20 | Free credits, 5 bits per type, type 0 in the low bits |

## Verification
The bench attacks three kinds of boundary:

- **Pool edges.** It consumes past zero and returns into a full pool. A design without the guards would wrap its free count, or raise a false update that the scoreboard reports as unexpected.
- **Counter wrap.** It pushes the header and data limits through their wrap points. A design with the wrong counter width would report the wrong cumulative value in the update.
- **Refresh timing.** It checks the refresh one tick before and exactly at the 30-tick and 120-tick limits. It also checks across an inactive stretch and after a single type was re-advertised by a freed credit. An early or missing refresh, a timer that survives link inactivity, or a timer that ignores the restart would show up as an extra or missing update.

Finally, the bench raises four requests at once without acknowledging them. A design with the wrong priority, or with a request that moves before it is acknowledged, would present the wrong type.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  localparam int NT = 4;   // finite credit types tracked

  typedef enum logic [1:0] {
    FC_PH  = 2'd0,
    FC_PD  = 2'd1,
    FC_NPH = 2'd2,
    FC_NPD = 2'd3
  } fc_type_e;

  localparam logic [2:0] LS_L0  = 3'd1;
  localparam logic [2:0] LS_L0S = 3'd2;

endpackage

// File: rtl/fc_credit_pool.sv
module fc_credit_pool #(
  parameter int POOL = 2,
  parameter int CW   = 8,
  parameter int FW   = 5,
  parameter int OW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          give_i,
  output logic [FW-1:0] free_o,
  output logic [OW-1:0] alloc_o,
  output logic          give_ok_o
);

  logic [FW-1:0] free_q, free_d;
  logic [CW-1:0] alloc_q, alloc_d;
  logic          take_ok;

  // next state
  always_comb begin
    take_ok   = take_i && (free_q != '0);
    give_ok_o = give_i && (free_q != FW'(POOL));
    free_d    = free_q - FW'(take_ok) + FW'(give_ok_o);
    alloc_d   = alloc_q + CW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= FW'(POOL);
      alloc_q <= CW'(POOL);
    end else begin
      if (take_ok || give_ok_o) free_q <= free_d;
      if (give_ok_o)            alloc_q <= alloc_d;
    end
  end

  assign free_o  = free_q;
  assign alloc_o = OW'(alloc_q);

  a_r3_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= FW'(POOL));

endmodule

// File: rtl/fc_refresh_timer.sv
module fc_refresh_timer #(
  parameter int STD_TICKS = 30,
  parameter int EXT_TICKS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ext_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic expire_o
);

  localparam int MAXT = (EXT_TICKS > STD_TICKS) ? EXT_TICKS : STD_TICKS;
  localparam int TW   = $clog2(MAXT + 2);

  logic [TW-1:0] cnt_q, cnt_d, lim;
  logic          hit_q, hit_d;

  // next state
  always_comb begin
    lim      = ext_i ? TW'(EXT_TICKS) : TW'(STD_TICKS);
    cnt_d    = cnt_q;
    hit_d    = hit_q;
    expire_o = 1'b0;
    if (!active_i || restart_i) begin
      cnt_d = '0;
      hit_d = 1'b0;
    end else if (tick_i) begin
      if (cnt_q < lim) cnt_d = cnt_q + TW'(1);
      if (!hit_q && ((cnt_q + TW'(1)) >= lim)) begin
        expire_o = 1'b1;
        hit_d    = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  // R10: no refresh may fire while the link is inactive
  a_r10_quiet_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> !expire_o);

endmodule

// File: rtl/fc_update_arb.sv
module fc_update_arb #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] req_i,
  input  logic          ack_i,
  output logic          vld_o,
  output logic [TW-1:0] typ_o,
  output logic [NT-1:0] gnt_o
);

  logic          vld_q, vld_d, load;
  logic [TW-1:0] typ_q, typ_d, pick;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (req_i[i]) pick = TW'(i);
    end
  end

  // next state
  always_comb begin
    gnt_o = '0;
    if (vld_q && ack_i) gnt_o[typ_q] = 1'b1;
    load  = !vld_q || ack_i;
    vld_d = |req_i;
    typ_d = pick;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      typ_q <= '0;
    end else if (load) begin
      vld_q <= vld_d;
      typ_q <= typ_d;
    end
  end

  assign vld_o = vld_q;
  assign typ_o = typ_q;

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ack_i) |=> (vld_q && $stable(typ_q)));

endmodule

// File: rtl/rx_fc_credit_adv.sv
module rx_fc_credit_adv
  import rxfc_pkg::*;
#(
  parameter int HDR_W     = 8,
  parameter int DAT_W     = 12,
  parameter int PH_POOL   = 2,
  parameter int PD_POOL   = 16,
  parameter int NPH_POOL  = 2,
  parameter int NPD_POOL  = 2,
  parameter int STD_TICKS = 30,
  parameter int EXT_TICKS = 120,
  parameter int MAXP_L    = (PH_POOL > PD_POOL) ? PH_POOL : PD_POOL,
  parameter int MAXP_R    = (NPH_POOL > NPD_POOL) ? NPH_POOL : NPD_POOL,
  parameter int FW        = $clog2(((MAXP_L > MAXP_R) ? MAXP_L : MAXP_R) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        link_state,
  input  logic              ext_sync,
  input  logic              us_tick,
  input  logic [3:0]        credit_take,
  input  logic [3:0]        credit_return,
  input  logic              upd_ack,
  output logic              upd_valid,
  output logic [1:0]        upd_type,
  output logic [DAT_W-1:0]  upd_count,
  output logic [HDR_W-1:0]  lim_ph,
  output logic [DAT_W-1:0]  lim_pd,
  output logic [HDR_W-1:0]  lim_nph,
  output logic [DAT_W-1:0]  lim_npd,
  output logic [HDR_W-1:0]  lim_cplh,
  output logic [DAT_W-1:0]  lim_cpld,
  output logic [4*FW-1:0]   avail
);

  localparam int TW = $clog2(NT);
  localparam int POOL_A [NT] = '{PH_POOL, PD_POOL, NPH_POOL, NPD_POOL};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic             link_active;
  logic [NT-1:0]    give_ok, expire, gnt, pend_q, pend_d;
  logic [DAT_W-1:0] alloc_all [NT];
  logic [FW-1:0]    free_all  [NT];

  assign link_active = (link_state == LS_L0) || (link_state == LS_L0S);

  for (genvar g = 0; g < NT; g++) begin : g_type
    localparam int CW = (g % 2 == 0) ? HDR_W : DAT_W;

    fc_credit_pool #(
      .POOL (POOL_A[g]),
      .CW   (CW),
      .FW   (FW),
      .OW   (DAT_W)
    ) u_pool (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .take_i    (credit_take[g]),
      .give_i    (credit_return[g]),
      .free_o    (free_all[g]),
      .alloc_o   (alloc_all[g]),
      .give_ok_o (give_ok[g])
    );

    fc_refresh_timer #(
      .STD_TICKS (STD_TICKS),
      .EXT_TICKS (EXT_TICKS)
    ) u_timer (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .active_i  (link_active),
      .ext_i     (ext_sync),
      .tick_i    (us_tick),
      .restart_i (gnt[g]),
      .expire_o  (expire[g])
    );

    assign avail[g*FW +: FW] = free_all[g];

    a_r4_return_flags: assert property (@(posedge clk) disable iff (!rst_s_n)
      give_ok[g] |=> pend_q[g]);
  end

  // pending requests: next state and register
  always_comb begin
    pend_d = (pend_q & ~gnt) | give_ok | expire;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  fc_update_arb #(
    .NT (NT),
    .TW (TW)
  ) u_arb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req_i (pend_d),
    .ack_i (upd_ack),
    .vld_o (upd_valid),
    .typ_o (upd_type),
    .gnt_o (gnt)
  );

  always_comb begin
    upd_count = alloc_all[upd_type];
  end

  assign lim_ph   = alloc_all[FC_PH][HDR_W-1:0];
  assign lim_pd   = alloc_all[FC_PD];
  assign lim_nph  = alloc_all[FC_NPH][HDR_W-1:0];
  assign lim_npd  = alloc_all[FC_NPD];
  assign lim_cplh = '0;
  assign lim_cpld = '0;

  a_r7_header_width: assert property (@(posedge clk) disable iff (!rst_s_n)
    (upd_valid && !upd_type[0]) |-> (upd_count[DAT_W-1:HDR_W] == '0));

endmodule

// File: tb/rx_fc_credit_adv_test.sv
module rx_fc_credit_adv_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 5;

  typedef struct {
    int typ;
    int cnt;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  link_state;
  logic        ext_sync, us_tick, upd_ack;
  logic [3:0]  credit_take, credit_return;
  logic        upd_valid;
  logic [1:0]  upd_type;
  logic [11:0] upd_count;
  logic [7:0]  lim_ph, lim_nph, lim_cplh;
  logic [11:0] lim_pd, lim_npd, lim_cpld;
  logic [19:0] avail;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  int    exp_alloc [4];
  bit    auto_ack = 1'b0;
  bit    done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_fc_credit_adv uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_state    (link_state),
    .ext_sync      (ext_sync),
    .us_tick       (us_tick),
    .credit_take   (credit_take),
    .credit_return (credit_return),
    .upd_ack       (upd_ack),
    .upd_valid     (upd_valid),
    .upd_type      (upd_type),
    .upd_count     (upd_count),
    .lim_ph        (lim_ph),
    .lim_pd        (lim_pd),
    .lim_nph       (lim_nph),
    .lim_npd       (lim_npd),
    .lim_cplh      (lim_cplh),
    .lim_cpld      (lim_cpld),
    .avail         (avail)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int free_of(input int t);
    return int'(avail[t*FW +: FW]);
  endfunction

  function automatic int mask_of(input int t);
    return (t % 2 == 0) ? 8'hFF : 12'hFFF;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_upd(input int t);
    item_t it;
    it.typ = t;
    it.cnt = exp_alloc[t];
    exp_q.push_back(it);
  endtask

  task automatic take(input int t);
    credit_take[t] = 1'b1;
    @(negedge clk);
    credit_take = '0;
  endtask

  // driver: a return that is accepted queues its expected update
  task automatic give(input int t, input bit accepted);
    if (accepted) begin
      exp_alloc[t] = (exp_alloc[t] + 1) & mask_of(t);
      expect_upd(t);
    end
    credit_return[t] = 1'b1;
    @(negedge clk);
    credit_return = '0;
  endtask

  task automatic tick();
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
    step(7);
  endtask

  task automatic ticks(input int n);
    repeat (n) tick();
  endtask

  task automatic expect_all();
    for (int t = 0; t < 4; t++) expect_upd(t);
  endtask

  task automatic quiet(input string req);
    chk(req, "upd_valid idle", int'(upd_valid), 0);
    chk(req, "pending expected", exp_q.size(), 0);
  endtask

  // monitor: compares each presented update against the scoreboard
  always @(posedge clk) begin
    #1;
    if (auto_ack && upd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R5 unexpected update type actual=%0d expected=none", upd_type);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk("R5", "update type", int'(upd_type), it.typ);
        chk("R7", "update count", int'(upd_count), it.cnt);
      end
      upd_ack = 1'b1;
    end else begin
      upd_ack = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    link_state = 3'd0;
    ext_sync = 1'b0;
    us_tick = 1'b0;
    upd_ack = 1'b0;
    credit_take = '0;
    credit_return = '0;
    exp_alloc = '{2, 16, 2, 2};
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state, R2 infinite completions
    chk("R1", "lim_ph", lim_ph, 2);
    chk("R1", "lim_pd", lim_pd, 16);
    chk("R1", "lim_nph", lim_nph, 2);
    chk("R1", "lim_npd", lim_npd, 2);
    chk("R1", "free pd", free_of(1), 16);
    chk("R1", "upd_valid", upd_valid, 0);
    chk("R2", "lim_cplh", lim_cplh, 0);
    chk("R2", "lim_cpld", lim_cpld, 0);
    auto_ack = 1'b1;

    // R3 consume, including past zero
    take(0);
    chk("R3", "free ph after one", free_of(0), 1);
    take(0);
    take(0);
    chk("R3", "free ph at zero", free_of(0), 0);
    chk("R3", "lim_ph unchanged", lim_ph, 2);
    step(3);
    quiet("R3");

    // R4 returns, and a return into a full pool
    give(0, 1'b1);
    chk("R4", "free ph", free_of(0), 1);
    chk("R4", "lim_ph", lim_ph, 3);
    step(3);
    give(0, 1'b1);
    step(3);
    give(0, 1'b0);
    step(4);
    chk("R4", "free ph full", free_of(0), 2);
    chk("R4", "lim_ph no change", lim_ph, 4);
    quiet("R4");

    // R5 / R6 priority and holding without acknowledge
    auto_ack = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 4; t++) take(t);
    credit_return = 4'hF;
    @(negedge clk);
    credit_return = '0;
    chk("R5", "first type", upd_type, 0);
    chk("R5", "valid", upd_valid, 1);
    step(3);
    chk("R6", "held valid", upd_valid, 1);
    chk("R6", "held type", upd_type, 0);
    for (int t = 0; t < 4; t++) begin
      exp_alloc[t] = (exp_alloc[t] + 1) & mask_of(t);
      expect_upd(t);
    end
    auto_ack = 1'b1;
    step(8);
    quiet("R6");

    // R7 header wrap modulo 256, data wrap modulo 4096
    for (int i = 0; i < 252; i++) begin
      take(0);
      give(0, 1'b1);
      step(2);
    end
    chk("R7", "lim_ph wrapped", lim_ph, 1);
    for (int i = 0; i < 4080; i++) begin
      take(1);
      give(1, 1'b1);
      step(2);
    end
    chk("R7", "lim_pd wrapped", lim_pd, 1);
    step(4);
    quiet("R7");

    // R8 refresh at 30 ticks, never earlier
    link_state = 3'd1;
    step(2);
    ticks(29);
    quiet("R8");
    expect_all();
    tick();
    step(4);
    chk("R8", "refresh done", exp_q.size(), 0);

    // R11 a freed credit restarts only its own timer
    ticks(10);
    take(2);
    give(2, 1'b1);
    step(6);
    ticks(19);
    quiet("R11");
    expect_upd(0);
    expect_upd(1);
    expect_upd(3);
    tick();
    ticks(9);
    quiet("R11");
    expect_upd(2);
    tick();
    step(2);
    chk("R11", "late refresh done", exp_q.size(), 0);

    // R10 inactive link clears timers
    ticks(5);
    link_state = 3'd3;
    ticks(50);
    quiet("R10");
    link_state = 3'd1;
    step(2);
    ticks(29);
    quiet("R10");
    expect_all();
    tick();
    step(2);
    chk("R10", "refresh after re-entry", exp_q.size(), 0);

    // R9 extended interval in L0s
    ext_sync = 1'b1;
    link_state = 3'd2;
    ticks(30);
    quiet("R9");
    ticks(89);
    quiet("R9");
    expect_all();
    tick();
    step(2);
    chk("R9", "extended refresh done", exp_q.size(), 0);

    step(10);
    quiet("R5");
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule